// File: doc/BRIEF.md
# Ethernet PHY Management Register Slave

This block is the management side of a 10/100 Ethernet transceiver. A station manager drives a slow serial clock and a shared bidirectional data line. The block decodes each serial frame: the start pattern, the opcode, a 5-bit device address, a 5-bit register address and the turnaround. When the device address matches the strapped address, the block either returns a 16-bit register value or stores a new one. The shared line is modelled as three plain signals: the input, the output value and the output enable.

The serial clock is asynchronous to the system clock. It is brought into the system clock domain through a short synchronizer, and its rising edges are detected there. Seven registers are implemented: control, status, two identifier words, local advertisement, partner ability and negotiation expansion. Live status, the resolved speed and duplex, the partner ability word and event pulses enter as plain inputs. The effective control settings leave as plain outputs.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset, the registers read as follows. Register 0 is 16'h1000 (bit 12, negotiation enable, set). Register 1 is 16'h7849 when link, negotiation-done, fault and jabber are all low. Register 2 is 16'h0000, register 3 is 16'h8201, register 4 is 16'h01E1, and registers 5 and 6 read 16'h0000 while their inputs are zero.
- R2: Until one frame has completed after reset, a start pattern is accepted only when at least 32 consecutive ones come before it. A frame with only 31 ones is not claimed: the line is never driven and a write does nothing.
- R3: Once a frame has completed, a frame that has no preamble is accepted, as long as at least one idle one comes before its start bit.
- R4: A start bit that comes directly after the last bit of a frame, with no idle one between them, is not accepted. The following frame is not claimed.
- R5: A frame whose device address differs from `phy_addr` is ignored. The line stays released, and a write to that address changes nothing.
- R6: In a claimed read, the line is released during the first turnaround bit and driven 0 in the second. It then carries the 16 data bits, most significant bit first. It is released again in the bit after the last data bit.
- R7: In register 4, only bits 13, 11, 10 and 8..0 can be written. A write of 16'hFFFF reads back as 16'h2DFF, and a write of 16'h0000 reads back as 16'h0000.
- R8: Writing register 0 with bit 15 set returns every register to its reset value. Bit 15 always reads 0.
- R9: When negotiation is enabled and `an_done` is high, register 0 bits 13 and 8 report `res_speed` and `res_duplex`. When negotiation is disabled, these bits report the written speed and duplex. Bits 14 (loopback) and 11 (power down) are read/write.
- R10: While `fiber_mode` is high, register 0 bit 13 reads 1 and bit 12 reads 0. Writes to these two bits are ignored in fiber mode, so the stored values are still there when fiber mode is left.
- R11: A pulse on `rem_fault` sets register 1 bit 4. Reading register 1 returns the bit set and then clears it. Bit 2 follows `link_up`.
- R12: A pulse on `page_evt` sets register 6 bit 1. Reading register 6 does not clear the bit; reading register 5 clears it. Register 5 reads `lp_ability`, and register 6 bit 0 reads `lp_an_able`.
- R13: A claimed read of any register address from 7 to 31 is driven as 16'h0000.
- R14: Writing register 0 with bit 9 set produces a single-cycle pulse on `an_restart`. Bit 9 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_addr | input | 5 | Strapped device address |
| fiber_mode | input | 1 | Fiber medium selected; speed is forced and negotiation is off |
| mdc | input | 1 | Management serial clock, asynchronous |
| mdio_i | input | 1 | Management data line, input side |
| mdio_o | output | 1 | Management data line, output value |
| mdio_oe | output | 1 | Management data line, output enable |
| link_up | input | 1 | Live link status |
| an_done | input | 1 | Negotiation complete |
| res_speed | input | 1 | Resolved speed, 1 = 100 Mb/s |
| res_duplex | input | 1 | Resolved duplex, 1 = full |
| jabber | input | 1 | Jabber condition |
| rem_fault | input | 1 | Remote fault event |
| page_evt | input | 1 | New link code word received |
| lp_an_able | input | 1 | Partner can negotiate |
| lp_ability | input | 16 | Partner ability word |
| ctl_loopback | output | 1 | Loopback setting |
| ctl_pwr_down | output | 1 | Power-down setting |
| ctl_speed100 | output | 1 | Effective speed |
| ctl_full_duplex | output | 1 | Effective duplex |
| ctl_an_enable | output | 1 | Effective negotiation enable |
| an_restart | output | 1 | One-cycle negotiation restart pulse |
| adv_word | output | 16 | Local advertisement word |

## Verification
The bench targets the framing corner cases. It sends a preamble of 31 ones, which a design with an off-by-one counter would accept as valid. It starts a frame back-to-back with the previous one, which a slave that drops the idle-bit rule would claim and answer. It uses a foreign device address, which a slave that skips address matching would drive the line for. It also checks the side effects on individual bits. If the fault bit were cleared by the wrong read, or the page bit by its own read, a second read would return a wrong value. If fiber-mode writes leaked into the stored bits, or a soft reset missed the advertisement word, the value read after leaving fiber mode or after the reset would be wrong.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    FS_IDLE, FS_ST2, FS_HDR, FS_TA, FS_DATA
  } fstate_t;

  localparam logic [1:0]  OP_RD     = 2'b10;
  localparam logic [1:0]  OP_WR     = 2'b01;
  localparam logic [4:0]  RA_CTRL   = 5'd0;
  localparam logic [4:0]  RA_STAT   = 5'd1;
  localparam logic [4:0]  RA_ID1    = 5'd2;
  localparam logic [4:0]  RA_ID2    = 5'd3;
  localparam logic [4:0]  RA_ADV    = 5'd4;
  localparam logic [4:0]  RA_LPA    = 5'd5;
  localparam logic [4:0]  RA_EXP    = 5'd6;
  localparam logic [15:0] ADV_RST   = 16'h01E1;
  localparam logic [15:0] ADV_WMASK = 16'h2DFF;
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc,
  input  logic mdio_in,
  output logic rise,
  output logic bit_out
);
  logic [STAGES:0]   mdc_sr;
  logic [STAGES-1:0] dat_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_sr  <= '0;
      dat_sr  <= '1;
      rise    <= 1'b0;
      bit_out <= 1'b1;
    end else begin
      mdc_sr  <= {mdc_sr[STAGES-1:0], mdc};
      dat_sr  <= {dat_sr[STAGES-2:0], mdio_in};
      rise    <= mdc_sr[STAGES-1] & ~mdc_sr[STAGES];
      bit_out <= dat_sr[STAGES-1];
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rise,
  input  logic        bit_in,
  input  logic [4:0]  phy_addr,
  input  logic [15:0] rd_data,
  output logic        rd_stb,
  output logic [4:0]  rd_addr,
  output logic        wr_stb,
  output logic [4:0]  wr_addr,
  output logic [15:0] wr_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int CW = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0] PRE_MAX = CW'(PRE_LEN);

  fstate_t       state;
  logic [CW-1:0] pre_cnt;
  logic          pre_ok;
  logic [10:0]   hdr;
  logic [3:0]    cnt;
  logic          is_rd, hit;
  logic [4:0]    addr_q;
  logic [15:0]   dshift;
  logic          start_ok, last_hdr, drive;

  assign start_ok = (pre_cnt == PRE_MAX) || (pre_ok && pre_cnt != '0);
  assign last_hdr = rise && state == FS_HDR && cnt == 4'd11;
  assign rd_addr  = {hdr[3:0], bit_in};
  assign rd_stb   = last_hdr && hdr[10:9] == OP_RD && hdr[8:4] == phy_addr;
  assign drive    = is_rd && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= FS_IDLE;
      pre_cnt <= '0;
      pre_ok  <= 1'b0;
      hdr     <= '0;
      cnt     <= '0;
      is_rd   <= 1'b0;
      hit     <= 1'b0;
      addr_q  <= '0;
      dshift  <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (rise) begin
        unique case (state)
          FS_IDLE: begin
            if (bit_in) begin
              if (pre_cnt != PRE_MAX) pre_cnt <= pre_cnt + 1'b1;
            end else if (start_ok) begin
              state   <= FS_ST2;
              pre_cnt <= '0;
            end else begin
              pre_cnt <= '0;
            end
          end
          FS_ST2: begin
            if (bit_in) begin
              state <= FS_HDR;
              cnt   <= '0;
            end else begin
              state <= FS_IDLE;
            end
          end
          FS_HDR: begin
            hdr <= {hdr[9:0], bit_in};
            cnt <= cnt + 1'b1;
            if (cnt == 4'd1 && ({hdr[0], bit_in} != OP_RD) && ({hdr[0], bit_in} != OP_WR)) begin
              state <= FS_IDLE;
            end else if (cnt == 4'd11) begin
              state   <= FS_TA;
              cnt     <= '0;
              addr_q  <= rd_addr;
              is_rd   <= (hdr[10:9] == OP_RD);
              hit     <= (hdr[8:4] == phy_addr);
              dshift  <= rd_data;
              mdio_oe <= 1'b0;
            end
          end
          FS_TA: begin
            if (cnt == 4'd0) begin
              cnt <= 4'd1;
              if (drive) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
              end
            end else begin
              state <= FS_DATA;
              cnt   <= '0;
              if (drive) begin
                mdio_o <= dshift[15];
                dshift <= {dshift[14:0], 1'b0};
              end
            end
          end
          FS_DATA: begin
            cnt <= cnt + 1'b1;
            if (drive) begin
              mdio_o <= dshift[15];
              dshift <= {dshift[14:0], 1'b0};
            end else begin
              dshift <= {dshift[14:0], bit_in};
            end
            if (cnt == 4'd15) begin
              state   <= FS_IDLE;
              pre_cnt <= '0;
              pre_ok  <= 1'b1;
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b1;
              wr_stb  <= !is_rd && hit;
              wr_addr <= addr_q;
              wr_data <= {dshift[14:0], bit_in};
            end
          end
          default: state <= FS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter logic [15:0] ID_HI = 16'h0000,
  parameter logic [15:0] ID_LO = 16'h8201
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fiber_mode,
  input  logic        link_up,
  input  logic        an_done,
  input  logic        res_speed,
  input  logic        res_duplex,
  input  logic        jabber,
  input  logic        rem_fault,
  input  logic        page_evt,
  input  logic        lp_an_able,
  input  logic [15:0] lp_ability,
  input  logic        rd_stb,
  input  logic [4:0]  rd_addr,
  input  logic        wr_stb,
  input  logic [4:0]  wr_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        rf_flag,
  output logic        page_flag,
  output logic        ctl_loopback,
  output logic        ctl_pwr_down,
  output logic        ctl_speed100,
  output logic        ctl_full_duplex,
  output logic        ctl_an_enable,
  output logic        an_restart,
  output logic [15:0] adv_word
);
  logic loop_q, spd_q, an_q, pdn_q, dup_q;
  logic an_eff, resolved, spd_rd, dup_rd, srst;

  assign an_eff   = an_q & ~fiber_mode;
  assign resolved = an_eff & an_done;
  assign spd_rd   = fiber_mode ? 1'b1 : (resolved ? res_speed : spd_q);
  assign dup_rd   = resolved ? res_duplex : dup_q;
  assign srst     = wr_stb && wr_addr == RA_CTRL && wr_data[15];

  assign ctl_loopback    = loop_q;
  assign ctl_pwr_down    = pdn_q;
  assign ctl_speed100    = spd_rd;
  assign ctl_full_duplex = dup_rd;
  assign ctl_an_enable   = an_eff;

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      loop_q     <= 1'b0;
      spd_q      <= 1'b0;
      an_q       <= 1'b1;
      pdn_q      <= 1'b0;
      dup_q      <= 1'b0;
      adv_word   <= ADV_RST;
      an_restart <= 1'b0;
    end else begin
      an_restart <= 1'b0;
      if (wr_stb && wr_addr == RA_CTRL) begin
        loop_q     <= wr_data[14];
        pdn_q      <= wr_data[11];
        dup_q      <= wr_data[8];
        an_restart <= wr_data[9];
        if (!fiber_mode) begin
          spd_q <= wr_data[13];
          an_q  <= wr_data[12];
        end
      end
      if (wr_stb && wr_addr == RA_ADV) adv_word <= wr_data & ADV_WMASK;
    end
  end

  // Event flags: a new event wins over a clearing read in the same cycle.
  always_ff @(posedge clk) begin
    if (rst || srst) begin
      rf_flag   <= 1'b0;
      page_flag <= 1'b0;
    end else begin
      if (rem_fault) rf_flag <= 1'b1;
      else if (rd_stb && rd_addr == RA_STAT) rf_flag <= 1'b0;
      if (page_evt) page_flag <= 1'b1;
      else if (rd_stb && rd_addr == RA_LPA) page_flag <= 1'b0;
    end
  end

  always_comb begin
    unique case (rd_addr)
      RA_CTRL: rd_data = {1'b0, loop_q, spd_rd, an_eff, pdn_q, 2'b00, dup_rd, 8'h00};
      RA_STAT: rd_data = {1'b0, 4'b1111, 4'b0000, 1'b1, an_done, rf_flag,
                          1'b1, link_up, jabber, 1'b1};
      RA_ID1:  rd_data = ID_HI;
      RA_ID2:  rd_data = ID_LO;
      RA_ADV:  rd_data = adv_word;
      RA_LPA:  rd_data = lp_ability;
      RA_EXP:  rd_data = {14'd0, page_flag, lp_an_able};
      default: rd_data = 16'h0000;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int          PRE_LEN = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] ID_HI = 16'h0000,
  parameter logic [15:0] ID_LO = 16'h8201
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  phy_addr,
  input  logic        fiber_mode,
  input  logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        link_up,
  input  logic        an_done,
  input  logic        res_speed,
  input  logic        res_duplex,
  input  logic        jabber,
  input  logic        rem_fault,
  input  logic        page_evt,
  input  logic        lp_an_able,
  input  logic [15:0] lp_ability,
  output logic        ctl_loopback,
  output logic        ctl_pwr_down,
  output logic        ctl_speed100,
  output logic        ctl_full_duplex,
  output logic        ctl_an_enable,
  output logic        an_restart,
  output logic [15:0] adv_word
);
  logic        rise, sbit;
  logic        rd_stb, wr_stb;
  logic [4:0]  rd_addr, wr_addr;
  logic [15:0] rd_data, wr_data;
  logic        rf_flag, page_flag;

  mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_in(mdio_i),
    .rise(rise), .bit_out(sbit)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk(clk), .rst(rst), .rise(rise), .bit_in(sbit), .phy_addr(phy_addr),
    .rd_data(rd_data), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_regs #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_regs (
    .clk(clk), .rst(rst), .fiber_mode(fiber_mode), .link_up(link_up),
    .an_done(an_done), .res_speed(res_speed), .res_duplex(res_duplex),
    .jabber(jabber), .rem_fault(rem_fault), .page_evt(page_evt),
    .lp_an_able(lp_an_able), .lp_ability(lp_ability),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data),
    .rf_flag(rf_flag), .page_flag(page_flag),
    .ctl_loopback(ctl_loopback), .ctl_pwr_down(ctl_pwr_down),
    .ctl_speed100(ctl_speed100), .ctl_full_duplex(ctl_full_duplex),
    .ctl_an_enable(ctl_an_enable), .an_restart(an_restart),
    .adv_word(adv_word)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        rd_stb,
  input logic [4:0]  rd_addr,
  input logic        wr_stb,
  input logic [4:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic        rem_fault,
  input logic        rf_flag,
  input logic        page_evt,
  input logic        page_flag,
  input logic        an_restart,
  input logic [15:0] adv_word
);
  // R6
  ta_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o);

  // R7
  adv_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr == RA_ADV) |=> adv_word == ($past(wr_data) & ADV_WMASK));

  // R8
  soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr == RA_CTRL && wr_data[15]) |=> adv_word == ADV_RST);

  // R11
  rf_set_chk: assert property (@(posedge clk) disable iff (rst)
    rem_fault |=> rf_flag);

  // R11
  rf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_addr == RA_STAT && !rem_fault) |=> !rf_flag);

  // R12
  page_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_addr == RA_LPA && !page_evt) |=> !page_flag);

  // R14
  restart_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    an_restart |=> !an_restart);
endmodule

bind mdio_mgmt_slave mdio_mgmt_chk u_chk (
  .clk(clk), .rst(rst), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .rd_stb(rd_stb), .rd_addr(rd_addr), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_data(wr_data), .rem_fault(rem_fault), .rf_flag(rf_flag),
  .page_evt(page_evt), .page_flag(page_flag), .an_restart(an_restart),
  .adv_word(adv_word)
);

// File: tb/sim_mdio_mgmt_slave.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_slave;
  localparam int HP = 8;
  localparam logic [4:0] MY = 5'b00001;
  localparam logic [4:0] OTHER = 5'b00010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fiber_mode = 1'b0, mdc = 1'b0;
  logic m_en = 1'b1, m_bit = 1'b1;
  logic mdio_i, mdio_o, mdio_oe;
  logic link_up = 1'b0, an_done = 1'b0, res_speed = 1'b0, res_duplex = 1'b0;
  logic jabber = 1'b0, rem_fault = 1'b0, page_evt = 1'b0, lp_an_able = 1'b0;
  logic [15:0] lp_ability = 16'h0000;
  logic ctl_loopback, ctl_pwr_down, ctl_speed100, ctl_full_duplex, ctl_an_enable;
  logic an_restart;
  logic [15:0] adv_word;

  int n_chk = 0, n_bad = 0, restart_cycles = 0;
  logic seen_oe = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  assign mdio_i = m_en ? m_bit : (mdio_oe ? mdio_o : 1'b1);

  mdio_mgmt_slave u0 (
    .clk(clk), .rst(rst), .phy_addr(MY), .fiber_mode(fiber_mode), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .link_up(link_up),
    .an_done(an_done), .res_speed(res_speed), .res_duplex(res_duplex),
    .jabber(jabber), .rem_fault(rem_fault), .page_evt(page_evt),
    .lp_an_able(lp_an_able), .lp_ability(lp_ability),
    .ctl_loopback(ctl_loopback), .ctl_pwr_down(ctl_pwr_down),
    .ctl_speed100(ctl_speed100), .ctl_full_duplex(ctl_full_duplex),
    .ctl_an_enable(ctl_an_enable), .an_restart(an_restart), .adv_word(adv_word)
  );

  always @(negedge clk) if (mdio_oe) seen_oe = 1'b1;
  always @(posedge clk) if (an_restart) restart_cycles++;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic slot(input logic en, input logic b, output logic s_oe, output logic s_o);
    m_en = en; m_bit = b;
    repeat (HP) @(negedge clk);
    s_oe = mdio_oe; s_o = mdio_o;
    mdc = 1'b1;
    repeat (HP) @(negedge clk);
    mdc = 1'b0;
  endtask

  task automatic send(input logic b);
    logic a, c;
    slot(1'b1, b, a, c);
  endtask

  task automatic rd_frame(input int pre, input logic [4:0] pa, input logic [4:0] ra,
                          output logic [15:0] d, output logic t1_oe,
                          output logic t2_ok, output logic end_oe);
    logic a, c;
    seen_oe = 1'b0;
    for (int i = 0; i < pre; i++) send(1'b1);
    send(1'b0); send(1'b1); send(1'b1); send(1'b0);
    for (int i = 4; i >= 0; i--) send(pa[i]);
    for (int i = 4; i >= 0; i--) send(ra[i]);
    slot(1'b0, 1'b1, a, c); t1_oe = a;
    slot(1'b0, 1'b1, a, c); t2_ok = a && !c;
    for (int i = 15; i >= 0; i--) begin
      slot(1'b0, 1'b1, a, c);
      d[i] = a ? c : 1'b1;
    end
    slot(1'b0, 1'b1, a, c); end_oe = a;
    m_en = 1'b1; m_bit = 1'b1;
  endtask

  task automatic wr_frame(input int pre, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] d, input int idle);
    for (int i = 0; i < pre; i++) send(1'b1);
    send(1'b0); send(1'b1); send(1'b0); send(1'b1);
    for (int i = 4; i >= 0; i--) send(pa[i]);
    for (int i = 4; i >= 0; i--) send(ra[i]);
    send(1'b1); send(1'b0);
    for (int i = 15; i >= 0; i--) send(d[i]);
    for (int i = 0; i < idle; i++) send(1'b1);
  endtask

  task automatic rd(input logic [4:0] ra, output logic [15:0] d);
    logic a, b, c;
    rd_frame(0, MY, ra, d, a, b, c);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_preamble;
    logic [15:0] d; logic a, b, c;
    wr_frame(31, MY, 5'd4, 16'h0000, 0);
    rd_frame(31, MY, 5'd2, d, a, b, c);
    chk("R2 short preamble read left line released", {15'd0, seen_oe}, 16'd0);
    rd_frame(32, MY, 5'd4, d, a, b, c);
    chk("R2 full preamble read claimed", {15'd0, b}, 16'd1);
    chk("R2 short preamble write ignored", d, 16'h01E1);
  endtask

  task automatic t_reset_vals;
    logic [15:0] d;
    rd(5'd0, d); chk("R1 reg0 reset", d, 16'h1000);
    rd(5'd1, d); chk("R1 reg1 reset", d, 16'h7849);
    rd(5'd2, d); chk("R1 reg2 id", d, 16'h0000);
    rd(5'd3, d); chk("R1 reg3 id", d, 16'h8201);
    rd(5'd4, d); chk("R1 reg4 reset", d, 16'h01E1);
    rd(5'd5, d); chk("R1 reg5 reset", d, 16'h0000);
    rd(5'd6, d); chk("R1 reg6 reset", d, 16'h0000);
  endtask

  task automatic t_timing;
    logic [15:0] d; logic a, b, c;
    rd_frame(0, MY, 5'd3, d, a, b, c);
    chk("R6 first turnaround released", {15'd0, a}, 16'd0);
    chk("R6 second turnaround driven 0", {15'd0, b}, 16'd1);
    chk("R6 data msb first", d, 16'h8201);
    chk("R6 released after data", {15'd0, c}, 16'd0);
  endtask

  task automatic t_idle;
    logic [15:0] d; logic a, b, c;
    wr_frame(0, MY, 5'd4, 16'h0021, 0);
    rd_frame(0, MY, 5'd2, d, a, b, c);
    chk("R4 back-to-back frame not claimed", {15'd0, seen_oe}, 16'd0);
    rd(5'd4, d);
    chk("R3 preamble-less write accepted", d, 16'h0021);
  endtask

  task automatic t_addr;
    logic [15:0] d; logic a, b, c;
    wr_frame(0, OTHER, 5'd4, 16'hFFFF, 1);
    rd_frame(0, OTHER, 5'd4, d, a, b, c);
    chk("R5 foreign read left line released", {15'd0, seen_oe}, 16'd0);
    rd(5'd4, d);
    chk("R5 foreign write ignored", d, 16'h0021);
  endtask

  task automatic t_mask;
    logic [15:0] d;
    wr_frame(0, MY, 5'd4, 16'hFFFF, 1);
    rd(5'd4, d); chk("R7 adv write ones", d, 16'h2DFF);
    chk("R7 adv_word port", adv_word, 16'h2DFF);
    wr_frame(0, MY, 5'd4, 16'h0000, 1);
    rd(5'd4, d); chk("R7 adv write zeros", d, 16'h0000);
  endtask

  task automatic t_srst;
    logic [15:0] d;
    restart_cycles = 0;
    wr_frame(0, MY, 5'd0, 16'h4A00, 1);
    rd(5'd0, d); chk("R9 loopback and power down rw", d, 16'h4800);
    chk("R9 ctl_loopback port", {15'd0, ctl_loopback}, 16'd1);
    chk("R14 restart one-cycle pulse", 16'(restart_cycles), 16'd1);
    wr_frame(0, MY, 5'd0, 16'h8000, 1);
    rd(5'd0, d); chk("R8 reg0 after soft reset", d, 16'h1000);
    rd(5'd4, d); chk("R8 reg4 after soft reset", d, 16'h01E1);
    chk("R8 loopback cleared", {15'd0, ctl_loopback}, 16'd0);
  endtask

  task automatic t_an;
    logic [15:0] d;
    an_done = 1'b1; res_speed = 1'b1; res_duplex = 1'b1;
    rd(5'd0, d); chk("R9 resolved speed/duplex", d, 16'h3100);
    chk("R9 ctl_speed100 port", {15'd0, ctl_speed100}, 16'd1);
    wr_frame(0, MY, 5'd0, 16'h2100, 1);
    res_speed = 1'b0; res_duplex = 1'b0;
    rd(5'd0, d); chk("R9 forced settings", d, 16'h2100);
    res_speed = 1'b1; res_duplex = 1'b1;
    wr_frame(0, MY, 5'd0, 16'h0000, 1);
    rd(5'd0, d); chk("R9 forced 10 half", d, 16'h0000);
    wr_frame(0, MY, 5'd0, 16'h1000, 1);
    rd(5'd0, d); chk("R9 re-enabled negotiation", d, 16'h3100);
    an_done = 1'b0;
    rd(5'd0, d); chk("R9 negotiation not done", d, 16'h1000);
  endtask

  task automatic t_fiber;
    logic [15:0] d;
    fiber_mode = 1'b1;
    rd(5'd0, d); chk("R10 fiber read forced", d, 16'h2000);
    wr_frame(0, MY, 5'd0, 16'h0100, 1);
    rd(5'd0, d); chk("R10 fiber write keeps forced bits", d, 16'h2100);
    fiber_mode = 1'b0;
    rd(5'd0, d); chk("R10 stored bits untouched", d, 16'h1100);
    wr_frame(0, MY, 5'd0, 16'h1000, 1);
  endtask

  task automatic t_status;
    logic [15:0] d; logic a, b, c;
    link_up = 1'b1;
    pulse(rem_fault);
    rd(5'd1, d); chk("R11 fault set and link", d, 16'h785D);
    rd(5'd1, d); chk("R11 fault cleared by read", d, 16'h784D);
    link_up = 1'b0;
    lp_an_able = 1'b1; lp_ability = 16'h45E1;
    pulse(page_evt);
    rd(5'd6, d); chk("R12 page flag set", d, 16'h0003);
    rd(5'd6, d); chk("R12 reg6 read keeps page flag", d, 16'h0003);
    rd(5'd5, d); chk("R12 partner ability", d, 16'h45E1);
    rd(5'd6, d); chk("R12 reg5 read cleared page flag", d, 16'h0001);
    rd_frame(0, MY, 5'd7, d, a, b, c);
    chk("R13 reg7 claimed", {15'd0, b}, 16'd1);
    chk("R13 reg7 reads zero", d, 16'h0000);
    rd(5'd31, d); chk("R13 reg31 reads zero", d, 16'h0000);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_preamble();
    t_reset_vals();
    t_timing();
    t_idle();
    t_addr();
    t_mask();
    t_srst();
    t_an();
    t_fiber();
    t_status();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule